// File: doc/BRIEF.md
# 8-bit ALU with Status Flags

This block is the combinational arithmetic and logic core of a small 8-bit processor datapath. Each cycle it takes two operands, a carry input, a 4-bit operation code and the six current status flags. It returns a result value, the updated flag byte and a mask that shows which flags the operation defines. It also returns a strobe that says whether the result should be written back to the register file. Flags that the operation does not define come out with the same value they went in with. The register file can therefore store `flags_out` every cycle without any further merging.

The operations are:
- addition with and without carry, subtraction with and without borrow, and the two compares;
- bitwise AND, OR and XOR, ones' complement and twos'-complement negate;
- increment and decrement.

Half-carry and overflow come from the sign and nibble bits of the operands and the result, not from a wider adder. The operand width is a parameter, and half-carry always comes from the middle bit position. Operand fetch, immediate decoding and multiplication are the job of the surrounding datapath.

Top module: `alu8_core`

## Requirements
- R1: Codes 0 (add) and 1 (add with carry) return A+B (plus `carry_in` for code 1), modulo 256. C is the carry out of bit 7, H is the carry out of bit 3, and V is set when the signed sum is outside -128..127. All six flags are written and `write_result` is 1.
- R2: Codes 2 (subtract) and 3 (subtract with borrow) return A-B (minus `carry_in` for code 3), modulo 256. C is the borrow out of bit 7, H is the borrow out of bit 3, and V is set when the signed difference is outside -128..127. All six flags are written.
- R3: Codes 4 and 5 compare. They produce the same result and flags as codes 2 and 3 on the same inputs, but `write_result` is 0.
- R4: For every written flag, N is result bit 7, Z is 1 only when the result is 0x00, and S equals N xor V.
- R5: Codes 6 (AND), 7 (OR) and 8 (XOR) return the bitwise function of A and B. V is forced to 0, and the write mask is S, V, N and Z only.
- R6: Code 9 returns 0xFF-A. It sets C to 1, clears V, and writes S, V, N, Z and C.
- R7: Code 10 returns 0x00-A and writes all six flags. C is 1 whenever A is nonzero, H is 1 when A's low nibble is nonzero, and V is 1 only for A = 0x80.
- R8: Codes 11 (increment) and 12 (decrement) return A+1 and A-1, wrapping. V is set only for 0x7F to 0x80 (increment) and 0x80 to 0x7F (decrement). The mask is S, V, N and Z, so C and H pass through.
- R9: The flag bit positions are C=0, Z=1, N=2, V=3, S=4 and H=5 in `flags_in`, `flags_out` and `flag_wr`. Any flag not set in `flag_wr` leaves on `flags_out` equal to `flags_in`.
- R10: Codes 13 to 15 are reserved. They return A unchanged, with `flag_wr` = 0, `write_result` = 0 and `flags_out` = `flags_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opd_a | input | WIDTH | Destination-side operand |
| opd_b | input | WIDTH | Source-side operand |
| carry_in | input | 1 | Stored C flag, used by codes 1, 3 and 5 |
| op_sel | input | 4 | Operation code |
| flags_in | input | 6 | Current status flags |
| result | output | WIDTH | Operation result |
| flags_out | output | 6 | Updated flags, unwritten bits passed through |
| flag_wr | output | 6 | Flags defined by this operation |
| write_result | output | 1 | Result write-back strobe |

## Verification
The bench targets the nibble boundary, such as 0x0F+0x01 and 0x10-0x01. A half-carry built from the wrong bit, or one that does not invert for borrows, gives the wrong H on those inputs. The signed edges 0x7F/0x80 under add, subtract, negate, increment and decrement expose a V term with an operand polarity swapped. Zero and all-ones operands with `carry_in` set show whether the carry reaches the subtract-with-borrow path and the compare-with-borrow path. Pre-set C and H around the logic and step operations catch a block that writes flags it should preserve. The reserved codes catch a decoder that falls into an arithmetic default.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

   typedef enum logic [3:0] {
      OP_ADD  = 4'd0,
      OP_ADDC = 4'd1,
      OP_SUB  = 4'd2,
      OP_SUBC = 4'd3,
      OP_CMP  = 4'd4,
      OP_CMPC = 4'd5,
      OP_AND  = 4'd6,
      OP_OR   = 4'd7,
      OP_XOR  = 4'd8,
      OP_COM  = 4'd9,
      OP_NEG  = 4'd10,
      OP_INC  = 4'd11,
      OP_DEC  = 4'd12
   } alu_op_e;

   localparam int NFLAGS = 6;
   localparam int FLG_C  = 0;
   localparam int FLG_Z  = 1;
   localparam int FLG_N  = 2;
   localparam int FLG_V  = 3;
   localparam int FLG_S  = 4;
   localparam int FLG_H  = 5;

   localparam logic [NFLAGS-1:0] MASK_ALL   = 6'b111111;
   localparam logic [NFLAGS-1:0] MASK_SVNZ  = 6'b011110;
   localparam logic [NFLAGS-1:0] MASK_SVNZC = 6'b011111;
   localparam logic [NFLAGS-1:0] MASK_NONE  = 6'b000000;

   typedef enum logic [1:0] {B_OPD, B_ONE, B_SELF} bsel_e;
   typedef enum logic [1:0] {SRC_ARITH, SRC_LOGIC, SRC_PASS} src_e;
   typedef enum logic [1:0] {LF_AND, LF_OR, LF_XOR, LF_NOT} lfn_e;

   typedef struct packed {
      logic              subtract;
      logic              use_cin;
      logic              zero_a;
      bsel_e             b_sel;
      lfn_e              lfn;
      src_e              src;
      logic              force_c;
      logic              clear_v;
      logic              wr;
      logic [NFLAGS-1:0] mask;
   } alu_ctrl_t;

endpackage

// File: rtl/alu8_decode.sv
module alu8_decode
   import alu8_pkg::*;
(
   input  logic [3:0] op,
   output alu_ctrl_t  ctrl
);

   always_comb begin
      ctrl          = '0;
      ctrl.b_sel    = B_OPD;
      ctrl.lfn      = LF_AND;
      ctrl.src      = SRC_ARITH;
      ctrl.wr       = 1'b1;
      ctrl.mask     = MASK_ALL;
      case (op)
         OP_ADD:  ;
         OP_ADDC: ctrl.use_cin = 1'b1;
         OP_SUB:  ctrl.subtract = 1'b1;
         OP_SUBC: begin ctrl.subtract = 1'b1; ctrl.use_cin = 1'b1; end
         OP_CMP:  begin ctrl.subtract = 1'b1; ctrl.wr = 1'b0; end
         OP_CMPC: begin
            ctrl.subtract = 1'b1;
            ctrl.use_cin  = 1'b1;
            ctrl.wr       = 1'b0;
         end
         OP_AND, OP_OR, OP_XOR: begin
            ctrl.src     = SRC_LOGIC;
            ctrl.lfn     = (op == OP_AND) ? LF_AND : (op == OP_OR) ? LF_OR : LF_XOR;
            ctrl.clear_v = 1'b1;
            ctrl.mask    = MASK_SVNZ;
         end
         OP_COM: begin
            ctrl.src     = SRC_LOGIC;
            ctrl.lfn     = LF_NOT;
            ctrl.clear_v = 1'b1;
            ctrl.force_c = 1'b1;
            ctrl.mask    = MASK_SVNZC;
         end
         OP_NEG: begin
            ctrl.subtract = 1'b1;
            ctrl.zero_a   = 1'b1;
            ctrl.b_sel    = B_SELF;
         end
         OP_INC: begin ctrl.b_sel = B_ONE; ctrl.mask = MASK_SVNZ; end
         OP_DEC: begin
            ctrl.subtract = 1'b1;
            ctrl.b_sel    = B_ONE;
            ctrl.mask     = MASK_SVNZ;
         end
         default: begin
            ctrl.src  = SRC_PASS;
            ctrl.wr   = 1'b0;
            ctrl.mask = MASK_NONE;
         end
      endcase
   end

endmodule

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             cin,
   input  logic             subtract,
   output logic [WIDTH-1:0] r,
   output logic             c_out,
   output logic             h_out,
   output logic             v_out
);

   localparam int MB = WIDTH - 1;
   localparam int HB = WIDTH / 2 - 1;

   logic [WIDTH-1:0] cin_ext;
   assign cin_ext = {{(WIDTH-1){1'b0}}, cin};

   always_comb begin
      if (subtract) begin
         r     = a - b - cin_ext;
         h_out = (~a[HB] & b[HB]) | (b[HB] & r[HB]) | (r[HB] & ~a[HB]);
         c_out = (~a[MB] & b[MB]) | (b[MB] & r[MB]) | (r[MB] & ~a[MB]);
         v_out = (a[MB] & ~b[MB] & ~r[MB]) | (~a[MB] & b[MB] & r[MB]);
      end else begin
         r     = a + b + cin_ext;
         h_out = (a[HB] & b[HB]) | (b[HB] & ~r[HB]) | (~r[HB] & a[HB]);
         c_out = (a[MB] & b[MB]) | (b[MB] & ~r[MB]) | (~r[MB] & a[MB]);
         v_out = (a[MB] & b[MB] & ~r[MB]) | (~a[MB] & ~b[MB] & r[MB]);
      end
   end

   logic [WIDTH:0] wide_sum;
   assign wide_sum = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};

   always_comb begin
      if (!$isunknown({a, b, cin, subtract}) && !subtract) begin
         AST_ADD_CARRY_MATCH: assert ({c_out, r} == wide_sum)
            else $error("carry formula disagrees with wide sum"); // R1
      end
   end

endmodule

// File: rtl/alu8_bitwise.sv
module alu8_bitwise
   import alu8_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  lfn_e             fn,
   output logic [WIDTH-1:0] y
);

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      always_comb begin
         unique case (fn)
            LF_AND:  y[i] = a[i] & b[i];
            LF_OR:   y[i] = a[i] | b[i];
            LF_XOR:  y[i] = a[i] ^ b[i];
            default: y[i] = ~a[i];
         endcase
      end
   end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
   import alu8_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0]  opd_a,
   input  logic [WIDTH-1:0]  opd_b,
   input  logic              carry_in,
   input  logic [3:0]        op_sel,
   input  logic [NFLAGS-1:0] flags_in,
   output logic [WIDTH-1:0]  result,
   output logic [NFLAGS-1:0] flags_out,
   output logic [NFLAGS-1:0] flag_wr,
   output logic              write_result
);

   localparam int MB = WIDTH - 1;

   if (WIDTH < 4 || (WIDTH % 2) != 0) begin : g_bad_width
      $error("alu8_core: WIDTH must be even and at least 4");
   end

   alu_ctrl_t ctrl;

   alu8_decode u_decode (
      .op   (op_sel),
      .ctrl (ctrl)
   );

   logic [WIDTH-1:0] ar_a, ar_b, ar_r, lg_y, value;
   logic             ar_c, ar_h, ar_v;

   assign ar_a = ctrl.zero_a ? '0 : opd_a;

   always_comb begin
      unique case (ctrl.b_sel)
         B_ONE:   ar_b = {{(WIDTH-1){1'b0}}, 1'b1};
         B_SELF:  ar_b = opd_a;
         default: ar_b = opd_b;
      endcase
   end

   alu8_addsub #(.WIDTH(WIDTH)) u_addsub (
      .a        (ar_a),
      .b        (ar_b),
      .cin      (ctrl.use_cin & carry_in),
      .subtract (ctrl.subtract),
      .r        (ar_r),
      .c_out    (ar_c),
      .h_out    (ar_h),
      .v_out    (ar_v)
   );

   alu8_bitwise #(.WIDTH(WIDTH)) u_bitwise (
      .a  (opd_a),
      .b  (opd_b),
      .fn (ctrl.lfn),
      .y  (lg_y)
   );

   always_comb begin
      unique case (ctrl.src)
         SRC_LOGIC: value = lg_y;
         SRC_PASS:  value = opd_a;
         default:   value = ar_r;
      endcase
   end

   logic              nf_z, nf_n, nf_v, nf_c;
   logic [NFLAGS-1:0] new_flags;

   assign nf_z = (value == '0);
   assign nf_n = value[MB];
   assign nf_v = ctrl.clear_v ? 1'b0 : ar_v;
   assign nf_c = ctrl.force_c ? 1'b1 : ar_c;

   always_comb begin
      new_flags        = '0;
      new_flags[FLG_C] = nf_c;
      new_flags[FLG_Z] = nf_z;
      new_flags[FLG_N] = nf_n;
      new_flags[FLG_V] = nf_v;
      new_flags[FLG_S] = nf_n ^ nf_v;
      new_flags[FLG_H] = ar_h;
   end

   assign result       = value;
   assign flag_wr      = ctrl.mask;
   assign flags_out    = (new_flags & ctrl.mask) | (flags_in & ~ctrl.mask);
   assign write_result = ctrl.wr;

   // Checks on port relations
   always_comb begin
      if (!$isunknown({opd_a, opd_b, carry_in, op_sel, flags_in})) begin
         AST_KEEP_UNWRITTEN: assert ((flags_out & ~flag_wr) == (flags_in & ~flag_wr))
            else $error("unwritten flag changed"); // R9
         AST_SIGN_IS_N_XOR_V: assert (!flag_wr[FLG_S] ||
                                      flags_out[FLG_S] == (flags_out[FLG_N] ^ flags_out[FLG_V]))
            else $error("S differs from N xor V"); // R4
         AST_CMP_NO_WRITE: assert (!(op_sel == OP_CMP || op_sel == OP_CMPC) || !write_result)
            else $error("compare requested write-back"); // R3
         AST_LOGIC_V_CLEAR: assert (!(op_sel == OP_AND || op_sel == OP_OR || op_sel == OP_XOR)
                                    || !flags_out[FLG_V])
            else $error("logic op left V set"); // R5
         AST_COM_CARRY_SET: assert (op_sel != OP_COM || flags_out[FLG_C])
            else $error("complement did not set C"); // R6
         AST_RESERVED_QUIET: assert (op_sel < 4'd13 || (flag_wr == '0 && !write_result))
            else $error("reserved code wrote state"); // R10
      end
   end

endmodule

// File: tb/alu8_core_tb.sv
module alu8_core_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] opd_a = '0, opd_b = '0;
   logic       carry_in = 1'b0;
   logic [3:0] op_sel = '0;
   logic [5:0] flags_in = '0;
   logic [7:0] result;
   logic [5:0] flags_out, flag_wr;
   logic       write_result;

   int  n_checks = 0;
   int  n_errors = 0;
   bit  done = 1'b0;

   always #10 clk = ~clk;

   alu8_core u_dut (
      .opd_a        (opd_a),
      .opd_b        (opd_b),
      .carry_in     (carry_in),
      .op_sel       (op_sel),
      .flags_in     (flags_in),
      .result       (result),
      .flags_out    (flags_out),
      .flag_wr      (flag_wr),
      .write_result (write_result)
   );

   function automatic string rtag(int op);
      case (op)
         0, 1:    return "R1";
         2, 3:    return "R2";
         4, 5:    return "R3";
         6, 7, 8: return "R5";
         9:       return "R6";
         10:      return "R7";
         11, 12:  return "R8";
         default: return "R10";
      endcase
   endfunction

   task automatic check(string req, string what, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Behavioural reference using plain integer arithmetic
   task automatic model(input int op, input int a, input int b, input int ci, input int fl,
                        output int r, output int fo, output int wm, output int wr);
      int sa, sb, ss, s, cx, c, h, v, n, z, nf;
      sa = (a > 127) ? a - 256 : a;
      sb = (b > 127) ? b - 256 : b;
      c = 0; h = 0; v = 0; wr = 1; wm = 63; r = 0;
      case (op)
         0, 1: begin
            cx = (op == 1) ? ci : 0;
            s  = a + b + cx;   r = s & 255; c = (s > 255);
            h  = ((a & 15) + (b & 15) + cx) > 15;
            ss = sa + sb + cx; v = (ss > 127 || ss < -128);
         end
         2, 3, 4, 5: begin
            cx = (op == 3 || op == 5) ? ci : 0;
            s  = a - b - cx;   r = s & 255; c = (s < 0);
            h  = ((a & 15) - (b & 15) - cx) < 0;
            ss = sa - sb - cx; v = (ss > 127 || ss < -128);
            wr = (op < 4);
         end
         6:  begin r = a & b; wm = 30; end
         7:  begin r = a | b; wm = 30; end
         8:  begin r = a ^ b; wm = 30; end
         9:  begin r = 255 - a; c = 1; wm = 31; end
         10: begin
            r = (256 - a) & 255; c = (a != 0); h = ((a & 15) != 0); v = (a == 128);
         end
         11: begin r = (a + 1) & 255;   v = (a == 127); wm = 30; end
         12: begin r = (a + 255) & 255; v = (a == 128); wm = 30; end
         default: begin r = a; wm = 0; wr = 0; end
      endcase
      n  = (r >= 128);
      z  = (r == 0);
      nf = (h << 5) | ((n ^ v) << 4) | (v << 3) | (n << 2) | (z << 1) | c;
      fo = (nf & wm) | (fl & ~wm & 63);
   endtask

   task automatic apply(int op, int a, int b, int ci, int fl);
      int er, efo, ewm, ewr;
      @(negedge clk);
      op_sel   = op[3:0];
      opd_a    = a[7:0];
      opd_b    = b[7:0];
      carry_in = ci[0];
      flags_in = fl[5:0];
      @(posedge clk);
      #2;
      model(op, a, b, ci, fl, er, efo, ewm, ewr);
      check(rtag(op), "result", int'(result), er);
      check(rtag(op), "flags_out", int'(flags_out), efo);
      check("R9", "flag_wr", int'(flag_wr), ewm);
      check("R9", "unwritten flags", int'(flags_out & ~flag_wr), fl & ~ewm & 63);
      check((op == 4 || op == 5) ? "R3" : rtag(op), "write_result", int'(write_result), ewr);
      if (ewm[4])
         check("R4", "S vs N^V", int'(flags_out[4]), int'(flags_out[2] ^ flags_out[3]));
      if (ewm[1])
         check("R4", "Z vs result", int'(flags_out[1]), int'(er == 0));
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_errors++;
         n_checks++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // first state after reset: all-zero add sets Z (R1, R4)
      apply(0, 8'h00, 8'h00, 0, 0);
      // R1 nibble carry, signed overflow, carry out, carry-in use
      apply(0, 8'h0F, 8'h01, 0, 0);
      apply(0, 8'h7F, 8'h01, 0, 0);
      apply(0, 8'hFF, 8'h01, 0, 6'h3F);
      apply(1, 8'hFF, 8'h00, 1, 0);
      apply(0, 8'h80, 8'h80, 1, 0);
      // R2 borrow cases
      apply(2, 8'h10, 8'h01, 0, 0);
      apply(2, 8'h80, 8'h01, 0, 0);
      apply(2, 8'h00, 8'h01, 0, 0);
      apply(3, 8'h00, 8'h00, 1, 0);
      apply(3, 8'h7F, 8'hFF, 1, 0);
      // R3 compares
      apply(4, 8'h05, 8'h05, 0, 0);
      apply(5, 8'h05, 8'h04, 1, 6'h21);
      apply(4, 8'h01, 8'h80, 0, 0);
      // R5 logic keeps C and H
      apply(6, 8'hF0, 8'h0F, 0, 6'h29);
      apply(7, 8'h80, 8'h01, 0, 6'h21);
      apply(8, 8'hAA, 8'hAA, 0, 6'h3F);
      // R6 complement
      apply(9, 8'h00, 8'h00, 0, 0);
      apply(9, 8'hFF, 8'h00, 0, 6'h20);
      // R7 negate
      apply(10, 8'h00, 8'h00, 0, 6'h3F);
      apply(10, 8'h80, 8'h00, 0, 0);
      apply(10, 8'h01, 8'h00, 0, 0);
      apply(10, 8'h10, 8'h00, 0, 0);
      // R8 increment and decrement keep C and H
      apply(11, 8'h7F, 8'h00, 1, 6'h21);
      apply(11, 8'hFF, 8'h00, 0, 6'h21);
      apply(12, 8'h80, 8'h00, 0, 6'h21);
      apply(12, 8'h00, 8'h00, 1, 0);
      // R10 reserved codes
      apply(13, 8'h5A, 8'h12, 1, 6'h15);
      apply(14, 8'h00, 8'hFF, 0, 6'h2A);
      apply(15, 8'hC3, 8'h3C, 1, 6'h3F);
      // mixed patterns across all codes
      for (int i = 0; i < 3000; i++) begin
         apply(int'($urandom_range(0, 15)), int'($urandom_range(0, 255)),
               int'($urandom_range(0, 255)), int'($urandom_range(0, 1)),
               int'($urandom_range(0, 63)));
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule